// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Unit

This block converts a segment value and an offset into a linear address. It has two modes. In real-address mode the 16-bit segment is shifted left by four bits and added to a 16-bit offset, which gives a 20-bit address. In protected mode the 16-bit segment is a selector. It picks a 64-bit descriptor from an internal table with two banks, one global and one local. The descriptor base is added to a 32-bit offset, and the offset is checked against the descriptor's limit.

Each request is accepted with `req_valid`. Exactly one cycle later the unit returns a single response with `rsp_valid`. That response carries either a linear address or a fault and its cause. The latency is the same in both modes. Software loads the descriptor table through a simple write port. The unit does not check privilege, does not cache descriptors and does no paging.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `rsp_valid` and `rsp_fault` are 0, and every table entry reads as a descriptor whose present bit is clear.
- R2: Every cycle with `req_valid` high produces exactly one cycle of `rsp_valid` in the next cycle. No response appears without a request. Both modes have the same latency.
- R3: When `req_mode` is 0 (real mode), `rsp_addr` equals (`req_seg`·16 + `req_off[15:0]`) modulo 2^20, zero-extended to 32 bits. `req_off[31:16]` is ignored. Real mode never faults, so every segment/offset pair that names the same address is accepted.
- R4: When `req_mode` is 1 (protected mode), the selector bits `req_seg[15:3]` give the entry index and `req_seg[2]` chooses the bank (0 global, 1 local). `req_seg[1:0]` is ignored.
- R5: The descriptor layout is: bits 31:0 base, bits 51:32 limit, bit 52 present, bit 55 granularity. Bits 54:53 and 63:56 are ignored. The effective limit is the 20-bit limit when granularity is 0. When granularity is 1 it is the limit shifted left by 12 with the low 12 bits filled with ones. With base 0, limit 0xFFFFF and granularity 1, every offset maps to itself.
- R6: A protected-mode result that does not fault is (base + `req_off`) modulo 2^32.
- R7: An offset greater than the effective limit faults with `rsp_cause` 1. An offset equal to the limit does not fault.
- R8: A descriptor whose present bit is clear faults with `rsp_cause` 2.
- R9: An index of `ENTRIES` or more faults with `rsp_cause` 3. The causes rank index over absent over limit. A fault response has `rsp_fault` 1 and `rsp_addr` 0. A response without a fault has `rsp_cause` 0.
- R10: When `tbl_we` is high, `tbl_wdata` is written into the entry with bank `tbl_waddr[IDX_W]` and index `tbl_waddr[IDX_W-1:0]`. A request in the same cycle as a write to the same entry sees the old content. A request in the following cycle sees the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_mode | input | 1 | 0 real mode, 1 protected mode |
| req_seg | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset |
| tbl_we | input | 1 | Descriptor table write enable |
| tbl_waddr | input | IDX_W+1 | Bank bit (MSB) and entry index |
| tbl_wdata | input | 64 | Descriptor to write |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr | output | 32 | Linear address, 0 on a fault |
| rsp_fault | output | 1 | Translation faulted |
| rsp_cause | output | 2 | 0 none, 1 limit, 2 absent, 3 index |

## Verification
The bench targets the points where a translation most often goes wrong.

- **Real-mode corners.** It checks the top-of-space sum FFFF:FFFF, which a unit without the 20-bit wrap would spill into bit 20. It sends offsets with junk in the upper half, which a careless design would add in. It sends several aliasing pairs, all of which must give the same address.
- **Protected-mode edges.** It checks an offset exactly at the limit against one past it, which catches an off-by-one compare. It checks a base near the top of the space, where the sum must wrap to a small address. It uses a flat granular descriptor to catch a wrong limit expansion, and a selector with its low two bits set to catch a wrong index slice.
- **Cause ordering.** It sends an absent descriptor with an out-of-limit offset, and an out-of-table index, to check the ranking of causes.
- **Same-cycle write.** It sends a write and a read of the same entry in one cycle. A design with write-through would return the new base there instead of the old one.

// File: rtl/seg_xlate_pkg.sv
// Shared types for the segmented address unit.
package seg_xlate_pkg;

   // Request mode encoding.
   typedef enum logic {
      MODE_REAL = 1'b0,
      MODE_PROT = 1'b1
   } xl_mode_e;

   // Fault cause encoding, ranked index > absent > limit.
   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_LIMIT  = 2'd1,
      FLT_ABSENT = 2'd2,
      FLT_INDEX  = 2'd3
   } xl_cause_e;

   // 64-bit descriptor, MSB first.
   typedef struct packed {
      logic [7:0]  attr_hi;   // 63:56 ignored
      logic        gran;      // 55
      logic [1:0]  attr_lo;   // 54:53 ignored
      logic        present;   // 52
      logic [19:0] limit;     // 51:32
      logic [31:0] base;      // 31:0
   } seg_desc_t;

   localparam int SEL_IDX_LSB = 3;
   localparam int SEL_BANK_BIT = 2;
   localparam int SEL_IDX_W = 13;
   localparam int PAGE_SHIFT = 12;

endpackage

// File: rtl/seg_desc_table.sv
// Two-bank descriptor store with a registered read port (read-before-write).
module seg_desc_table
   import seg_xlate_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int ENT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W:0]   wr_addr,
   input  logic [63:0]      wr_data,
   input  logic             rd_en,
   input  logic             rd_bank,
   input  logic [IDX_W-1:0] rd_idx,
   output seg_desc_t        rd_desc
);

   localparam logic [ENT_W-1:0] ENT_LIM = ENT_W'(ENTRIES);

   logic [63:0] bank_rd [2];
   logic        wr_idx_ok;
   logic        rd_idx_ok;
   seg_desc_t   rd_q;

   assign wr_idx_ok = {1'b0, wr_addr[IDX_W-1:0]} < ENT_LIM;
   assign rd_idx_ok = {1'b0, rd_idx} < ENT_LIM;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [63:0] ent_q [ENTRIES];
      logic        hit_w;

      assign hit_w = wr_en && wr_idx_ok && (wr_addr[IDX_W] == 1'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
               ent_q[i] <= '0;
            end
         end else if (hit_w) begin
            ent_q[wr_addr[IDX_W-1:0]] <= wr_data;
         end
      end

      assign bank_rd[b] = rd_idx_ok ? ent_q[rd_idx] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_en) begin
         rd_q <= seg_desc_t'(bank_rd[rd_bank]);
      end
   end

   assign rd_desc = rd_q;

endmodule

// File: rtl/seg_real_path.sv
// Real-mode shift-and-add. REAL_WRAP picks a 20-bit wrap or a 21-bit carry-out.
module seg_real_path #(
   parameter bit REAL_WRAP = 1'b1
) (
   input  logic [15:0] seg,
   input  logic [15:0] off,
   output logic [31:0] lin_addr
);

   if (REAL_WRAP) begin : g_wrap
      logic [19:0] sum20;
      assign sum20 = {seg, 4'h0} + {4'h0, off};
      assign lin_addr = {12'h000, sum20};
   end else begin : g_carry
      logic [20:0] sum21;
      assign sum21 = {1'b0, seg, 4'h0} + {5'h00, off};
      assign lin_addr = {11'h000, sum21};
   end

endmodule

// File: rtl/seg_prot_path.sv
// Protected-mode base add, limit expansion and fault ranking.
module seg_prot_path
   import seg_xlate_pkg::*;
(
   input  seg_desc_t   desc,
   input  logic [31:0] off,
   input  logic        idx_ok,
   output logic [31:0] lin_addr,
   output logic [1:0]  cause
);

   logic [31:0] eff_limit;
   logic        over_limit;
   logic [9:0]  unused_attr;

   assign unused_attr = {desc.attr_hi, desc.attr_lo};

   assign eff_limit = desc.gran ? {desc.limit, {PAGE_SHIFT{1'b1}}}
                                : {12'h000, desc.limit};
   assign over_limit = off > eff_limit;
   assign lin_addr = desc.base + off;

   always_comb begin
      if (!idx_ok) begin
         cause = FLT_INDEX;
      end else if (!desc.present) begin
         cause = FLT_ABSENT;
      end else if (over_limit) begin
         cause = FLT_LIMIT;
      end else begin
         cause = FLT_NONE;
      end
   end

endmodule

// File: rtl/seg_xlate_unit.sv
// Top: captures a request, reads the descriptor, and drives one response a cycle later.
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter bit REAL_WRAP = 1'b1,
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_mode,
   input  logic [15:0]      req_seg,
   input  logic [31:0]      req_off,
   input  logic             tbl_we,
   input  logic [IDX_W:0]   tbl_waddr,
   input  logic [63:0]      tbl_wdata,
   output logic             rsp_valid,
   output logic [31:0]      rsp_addr,
   output logic             rsp_fault,
   output logic [1:0]       rsp_cause
);

   initial begin : elab_chk
      assert (ENTRIES >= 1 && ENTRIES <= (1 << SEL_IDX_W))
         else $error("ENTRIES must lie in 1..8192");
   end

   localparam logic [SEL_IDX_W:0] ENT_CMP = (SEL_IDX_W + 1)'(ENTRIES);

   logic [SEL_IDX_W-1:0] sel_idx;
   logic                 sel_idx_ok;
   logic                 is_prot;

   assign sel_idx = req_seg[15:SEL_IDX_LSB];
   assign sel_idx_ok = {1'b0, sel_idx} < ENT_CMP;
   assign is_prot = (xl_mode_e'(req_mode) == MODE_PROT);

   // Stage registers
   logic        s_valid;
   logic        s_prot;
   logic        s_idx_ok;
   logic [15:0] s_seg;
   logic [31:0] s_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid  <= 1'b0;
         s_prot   <= 1'b0;
         s_idx_ok <= 1'b0;
         s_seg    <= '0;
         s_off    <= '0;
      end else begin
         s_valid <= req_valid;
         if (req_valid) begin
            s_prot   <= is_prot;
            s_idx_ok <= sel_idx_ok;
            s_seg    <= req_seg;
            s_off    <= req_off;
         end
      end
   end

   seg_desc_t   desc;
   logic [31:0] real_addr;
   logic [31:0] prot_addr;
   logic [1:0]  prot_cause;

   seg_desc_table #(.ENTRIES(ENTRIES)) table_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_addr (tbl_waddr),
      .wr_data (tbl_wdata),
      .rd_en   (req_valid && is_prot),
      .rd_bank (req_seg[SEL_BANK_BIT]),
      .rd_idx  (req_seg[SEL_IDX_LSB +: IDX_W]),
      .rd_desc (desc)
   );

   seg_real_path #(.REAL_WRAP(REAL_WRAP)) real_i (
      .seg      (s_seg),
      .off      (s_off[15:0]),
      .lin_addr (real_addr)
   );

   seg_prot_path prot_i (
      .desc     (desc),
      .off      (s_off),
      .idx_ok   (s_idx_ok),
      .lin_addr (prot_addr),
      .cause    (prot_cause)
   );

   logic [1:0] cause_w;
   assign cause_w = s_prot ? prot_cause : FLT_NONE;

   assign rsp_valid = s_valid;
   assign rsp_cause = s_valid ? cause_w : FLT_NONE;
   assign rsp_fault = s_valid && (cause_w != FLT_NONE);
   assign rsp_addr  = (!s_valid || cause_w != FLT_NONE) ? '0
                    : (s_prot ? prot_addr : real_addr);

endmodule

// File: rtl/seg_xlate_chk.sv
// Property checker bound to the top.
module seg_xlate_chk #(
   parameter bit REAL_WRAP = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_mode,
   input logic        rsp_valid,
   input logic [31:0] rsp_addr,
   input logic        rsp_fault,
   input logic [1:0]  rsp_cause
);

   AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                   // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);                                 // R2
   AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_mode) |=> !rsp_fault);                   // R3
   AST_REAL_ADDR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_mode) |=> (rsp_addr[31:21] == 11'h000)); // R3
   AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_valid && rsp_addr == 32'h0));            // R9
   AST_CAUSE_MATCHES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));          // R9

   if (REAL_WRAP) begin : g_wrap_chk
      AST_REAL_WRAP_20: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !req_mode) |=> !rsp_addr[20]);             // R3
   end

endmodule

bind seg_xlate_unit seg_xlate_chk #(.REAL_WRAP(REAL_WRAP)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_mode  (req_mode),
   .rsp_valid (rsp_valid),
   .rsp_addr  (rsp_addr),
   .rsp_fault (rsp_fault),
   .rsp_cause (rsp_cause)
);

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_mode = 1'b0;
   logic [15:0] req_seg = '0;
   logic [31:0] req_off = '0;
   logic        tbl_we = 1'b0;
   logic [4:0]  tbl_waddr = '0;
   logic [63:0] tbl_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_addr;
   logic        rsp_fault;
   logic [1:0]  rsp_cause;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   seg_xlate_unit #(.ENTRIES(16), .REAL_WRAP(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_seg(req_seg), .req_off(req_off), .tbl_we(tbl_we),
      .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata), .rsp_valid(rsp_valid),
      .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
   );

   // Bench-side copy of the table, updated from the requirements only.
   logic [63:0] shadow [2][16];

   typedef struct {
      logic [31:0] addr;
      logic        flt;
      logic [1:0]  cause;
      string       tag;
   } exp_t;

   exp_t q[$];

   function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                      input logic p, input logic g, input logic [7:0] attr);
      return {attr, g, 2'b11, p, lim, base};
   endfunction

   function automatic exp_t model(input logic md, input logic [15:0] sg,
                                  input logic [31:0] of, input string tag);
      exp_t e;
      logic [19:0] s20;
      logic [63:0] d;
      logic [31:0] lim;
      e.tag = tag; e.addr = '0; e.flt = 1'b0; e.cause = 2'd0;
      if (!md) begin
         s20 = {sg, 4'h0} + {4'h0, of[15:0]};
         e.addr = {12'h000, s20};
      end else if (sg[15:3] >= 13'd16) begin
         e.flt = 1'b1; e.cause = 2'd3;
      end else begin
         d = shadow[sg[2]][sg[6:3]];
         lim = d[55] ? {d[51:32], 12'hFFF} : {12'h000, d[51:32]};
         if (!d[52]) begin
            e.flt = 1'b1; e.cause = 2'd2;
         end else if (of > lim) begin
            e.flt = 1'b1; e.cause = 2'd1;
         end else begin
            e.addr = d[31:0] + of;
         end
      end
      return e;
   endfunction

   // Driver: one cycle of stimulus, expectation pushed before the table copy changes.
   task automatic cyc(input logic we, input logic [4:0] wa, input logic [63:0] wd,
                      input logic rv, input logic md, input logic [15:0] sg,
                      input logic [31:0] of, input string tag);
      @(negedge clk);
      tbl_we = we; tbl_waddr = wa; tbl_wdata = wd;
      req_valid = rv; req_mode = md; req_seg = sg; req_off = of;
      if (rv) q.push_back(model(md, sg, of, tag));
      if (we) shadow[wa[4]][wa[3:0]] = wd;
   endtask

   task automatic rq(input logic md, input logic [15:0] sg, input logic [31:0] of,
                     input string tag);
      cyc(1'b0, 5'h0, 64'h0, 1'b1, md, sg, of, tag);
   endtask

   task automatic wr(input logic [4:0] wa, input logic [63:0] wd);
      cyc(1'b1, wa, wd, 1'b0, 1'b0, 16'h0, 32'h0, "");
   endtask

   task automatic idle();
      cyc(1'b0, 5'h0, 64'h0, 1'b0, 1'b0, 16'h0, 32'h0, "");
   endtask

   // Monitor: samples 5 ns after each rising edge.
   always @(posedge clk) begin
      exp_t e;
      #5;
      if (rst_n) begin
         if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (rsp_valid !== 1'b1 || rsp_addr !== e.addr ||
                rsp_fault !== e.flt || rsp_cause !== e.cause) begin
               errors++;
               $display("FAIL %s: valid=%b addr=%h fault=%b cause=%0d expected valid=1 addr=%h fault=%b cause=%0d",
                        e.tag, rsp_valid, rsp_addr, rsp_fault, rsp_cause,
                        e.addr, e.flt, e.cause);
            end
         end else if (rsp_valid !== 1'b0) begin
            checks++;
            errors++;
            $display("FAIL R2 response without request: valid=%b expected 0", rsp_valid);
         end
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
   end

   localparam logic [63:0] D_SMALL = 64'h0;

   initial begin : main
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 16; i++)
            shadow[b][i] = '0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset state: valid=%b fault=%b expected 0 0", rsp_valid, rsp_fault);
      end

      // R1 / R8: a cleared table reads as absent.
      rq(1'b1, 16'h0008, 32'h0, "R1 cleared entry absent");
      rq(1'b1, 16'h007C, 32'h0, "R8 cleared local entry absent");

      // R3 real mode, aliases, wrap, ignored upper offset.
      rq(1'b0, 16'h08F1, 32'h0000_0100, "R3 real basic");
      rq(1'b0, 16'h028F, 32'h0000_0030, "R3 real second");
      rq(1'b0, 16'h28F0, 32'h0000_0030, "R3 alias a");
      rq(1'b0, 16'h28F3, 32'h0000_0000, "R3 alias b");
      rq(1'b0, 16'h28B0, 32'h0000_0430, "R3 alias c");
      rq(1'b0, 16'hFFFF, 32'h0000_FFFF, "R3 wrap at 1MB");
      rq(1'b0, 16'h1234, 32'hABCD_0010, "R3 upper offset ignored");
      idle();

      // R10 table load.
      wr(5'h01, mk(32'h0010_0000, 20'h00FFF, 1'b1, 1'b0, 8'hA5));
      wr(5'h11, mk(32'hFFFF_F000, 20'h01FFF, 1'b1, 1'b0, 8'h00));
      wr(5'h02, mk(32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 8'h9A));
      wr(5'h03, mk(32'h5000_0000, 20'h00010, 1'b0, 1'b0, 8'hFF));
      wr(5'h1F, mk(32'h1234_0000, 20'h00010, 1'b1, 1'b1, 8'h3C));

      rq(1'b1, 16'h0008, 32'h0,          "R6 base plus zero");
      rq(1'b1, 16'h000B, 32'h0000_0FFF,  "R4 low selector bits ignored, R7 at limit");
      rq(1'b1, 16'h0008, 32'h0000_1000,  "R7 one past limit");
      rq(1'b1, 16'h000C, 32'h0000_1FFF,  "R4 local bank, R6 wrap mod 2^32");
      rq(1'b1, 16'h0010, 32'hFFFF_FFFF,  "R5 flat top offset");
      rq(1'b1, 16'h0010, 32'h89AB_CDEF,  "R5 flat identity");
      rq(1'b1, 16'h0018, 32'h0,          "R8 absent descriptor");
      rq(1'b1, 16'h0018, 32'hFFFF_FFFF,  "R9 absent ranks over limit");
      rq(1'b1, 16'h0080, 32'h0,          "R9 index beyond table");
      rq(1'b1, 16'hFFFF, 32'hFFFF_FFFF,  "R9 index ranks over all");
      rq(1'b1, 16'h007C, 32'h0001_0FFF,  "R5 granular limit edge");
      rq(1'b1, 16'h007C, 32'h0001_1000,  "R7 granular limit exceeded");
      idle();

      // R10 same-cycle write and read: old content, then new.
      cyc(1'b1, 5'h01, mk(32'h2000_0000, 20'h00FFF, 1'b1, 1'b0, 8'h00),
          1'b1, 1'b1, 16'h0008, 32'h4, "R10 read sees old entry");
      rq(1'b1, 16'h0008, 32'h4, "R10 read sees new entry");

      // R2 back-to-back alternating modes.
      for (int k = 0; k < 6; k++) begin
         rq(k[0], (k[0] ? 16'h0010 : 16'h4000 + 16'(k)), 32'h100 * k, "R2 back-to-back mix");
      end
      idle();
      idle();
      idle();

      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R2 missing responses: pending=%0d expected 0", q.size());
      end
      summary();
      $finish;
   end

endmodule